// File: doc/BRIEF.md
# Channel-Tagged Bulk Packet Multiplexer

This block shares one upstream bulk pipe between several byte producers. Each producer owns a byte FIFO and a flush request line. The block grants the pipe to one channel at a time. For each grant it emits a single tag byte carrying that channel's index, then streams bytes from that channel's FIFO. A one-cycle commit strobe closes the packet and reports its total length, tag included.

A packet closes in two cases. The first is when the payload reaches the size limit, which keeps the whole packet within one bulk transfer. The second is when a requested flush finds the owning FIFO empty. A flush that arrives when a channel has no data still produces a packet holding only the tag byte, so the receiver never sees a zero-length transfer. Every packet holds bytes from exactly one channel. Channels take turns in round-robin order, one packet per grant.

Top module: `pkt_mux`

## Requirements
- R1: The first byte of every packet is the channel index of the granted channel, zero-extended to 8 bits.
- R2: Payload bytes are the granted channel's FIFO bytes in FIFO order, and at most one `ch_ready` bit is high in any cycle.
- R3: A packet carries at most MAX_PAYLOAD (default 511) payload bytes. A channel holding more data than that produces a full packet (`pkt_len` = MAX_PAYLOAD+1) followed by further packets.
- R4: `pkt_commit` is a single-cycle pulse after the packet's last byte. In that cycle `pkt_len` equals 1 plus the number of payload bytes in the packet, and `out_valid` is low.
- R5: A channel that is not full only commits when its flush is pending and its FIFO has run empty. Bytes queued before the flush all go into the packet, and without a flush a granted packet stays open.
- R6: A flush on a channel with an empty FIFO yields a packet of length 1 that holds only the tag byte.
- R7: `ch_ready` is low during the commit cycle and is only high for a channel whose `ch_valid` is high, so no byte is popped without being emitted.
- R8: Grants rotate: the next granted channel is the first requester after the previously granted one, counting upward with wrap-around. After reset the search starts at channel 0.
- R9: While reset is held and right after it, `out_valid`, `pkt_commit` and `ch_ready` are all low.
- R10: A flush pulse is remembered until the flush packet of that channel commits. A channel with neither data nor a pending flush is never granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_valid | input | N_CH | Per-channel FIFO not empty |
| ch_data | input | 8*N_CH | Per-channel FIFO head byte, channel i at bits [8i+7:8i] |
| ch_flush | input | N_CH | Per-channel single-cycle flush request |
| ch_ready | output | N_CH | Per-channel pop strobe |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte (tag or payload) |
| pkt_commit | output | 1 | Packet close strobe |
| pkt_len | output | LEN_W (10) | Packet length including tag, valid with pkt_commit |

## Verification
The bench pushes a payload of more than 511 bytes behind one flush. A design that miscounted the limit would emit a 513-byte packet or drop the byte at the boundary, and a design that lost the pending flush at the full commit would leave the tail stranded. Empty flushes must produce length-1 tag-only packets, where a faulty design would emit nothing or stall. Three channels loaded in the same cycle must come out in rotated order after the last grant, which catches fixed-priority or off-by-one pointer errors. A channel with data but no flush must hold its packet open; a design that closed on a drained FIFO would commit early.

// File: rtl/pmx_pkg.sv
package pmx_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_TAG    = 2'd1,
        ST_BODY   = 2'd2,
        ST_CLOSE  = 2'd3
    } pmx_state_e;

    // Tag byte placed at the front of every packet.
    function automatic logic [BYTE_W-1:0] tag_byte(input logic [BYTE_W-1:0] chan);
        return chan;
    endfunction

endpackage

// File: rtl/pmx_rr_arbiter.sv
module pmx_rr_arbiter #(
    parameter int N_CH = 4,
    localparam int ID_W = $clog2(N_CH),
    localparam int CW   = ID_W + 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N_CH-1:0] req,
    input  logic            take,
    output logic            pick_valid,
    output logic [ID_W-1:0] pick_idx,
    output logic [ID_W-1:0] owner_idx
);
    logic [ID_W-1:0] last_q;

    always_comb begin
        pick_valid = 1'b0;
        pick_idx   = '0;
        for (int k = 1; k <= N_CH; k++) begin
            logic [CW-1:0] cand;
            cand = {1'b0, last_q} + CW'(k);
            if (cand >= CW'(N_CH)) cand = cand - CW'(N_CH);
            if (!pick_valid && req[cand[ID_W-1:0]]) begin
                pick_valid = 1'b1;
                pick_idx   = cand[ID_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)       last_q <= ID_W'(N_CH - 1);
        else if (take) last_q <= pick_idx;
    end

    assign owner_idx = last_q;
endmodule

// File: rtl/pmx_framer.sv
module pmx_framer
    import pmx_pkg::*;
#(
    parameter int MAX_PAYLOAD = 511,
    localparam int CNT_W = $clog2(MAX_PAYLOAD + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pick_valid,
    input  logic             sel_valid,
    input  logic             sel_flush,
    output logic             take,
    output logic             tag_phase,
    output logic             pop,
    output logic             close,
    output logic             flush_done,
    output logic [CNT_W-1:0] count
);
    pmx_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             full;

    always_comb begin
        full      = (cnt_q == CNT_W'(MAX_PAYLOAD));
        take      = (state_q == ST_IDLE) && pick_valid;
        tag_phase = (state_q == ST_TAG);
        pop       = (state_q == ST_BODY) && sel_valid && !full;
        close     = (state_q == ST_CLOSE);
        flush_done = close && !full;
        state_d   = state_q;
        unique case (state_q)
            ST_IDLE:  if (pick_valid) state_d = ST_TAG;
            ST_TAG:   state_d = ST_BODY;
            ST_BODY:  if (full || (sel_flush && !sel_valid)) state_d = ST_CLOSE;
            ST_CLOSE: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (take)     cnt_q <= '0;
            else if (pop) cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign count = cnt_q;
endmodule

// File: rtl/pmx_flush_hold.sv
module pmx_flush_hold #(
    parameter int N_CH = 4,
    localparam int ID_W = $clog2(N_CH)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N_CH-1:0] flush_in,
    input  logic            done,
    input  logic [ID_W-1:0] done_idx,
    output logic [N_CH-1:0] pending
);
    for (genvar i = 0; i < N_CH; i++) begin : g_hold
        always_ff @(posedge clk) begin
            if (rst)                                  pending[i] <= 1'b0;
            else if (flush_in[i])                     pending[i] <= 1'b1;
            else if (done && done_idx == ID_W'(i))    pending[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/pkt_mux.sv
module pkt_mux
    import pmx_pkg::*;
#(
    parameter int N_CH        = 4,
    parameter int MAX_PAYLOAD = 511,
    localparam int ID_W  = $clog2(N_CH),
    localparam int CNT_W = $clog2(MAX_PAYLOAD + 1),
    localparam int LEN_W = $clog2(MAX_PAYLOAD + 2)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [N_CH-1:0]          ch_valid,
    input  logic [BYTE_W*N_CH-1:0]   ch_data,
    input  logic [N_CH-1:0]          ch_flush,
    output logic [N_CH-1:0]          ch_ready,
    output logic                     out_valid,
    output logic [BYTE_W-1:0]        out_data,
    output logic                     pkt_commit,
    output logic [LEN_W-1:0]         pkt_len
);
    logic [N_CH-1:0]   flush_pend;
    logic [N_CH-1:0]   req;
    logic              pick_valid, take, tag_phase, pop, close, flush_done;
    logic [ID_W-1:0]   pick_idx, owner;
    logic [CNT_W-1:0]  count;
    logic              sel_valid, sel_flush;
    logic [BYTE_W-1:0] sel_data;

    assign req = ch_valid | flush_pend;

    pmx_rr_arbiter #(.N_CH(N_CH)) u_arb (
        .clk(clk), .rst(rst), .req(req), .take(take),
        .pick_valid(pick_valid), .pick_idx(pick_idx), .owner_idx(owner)
    );

    pmx_flush_hold #(.N_CH(N_CH)) u_hold (
        .clk(clk), .rst(rst), .flush_in(ch_flush),
        .done(flush_done), .done_idx(owner), .pending(flush_pend)
    );

    pmx_framer #(.MAX_PAYLOAD(MAX_PAYLOAD)) u_frm (
        .clk(clk), .rst(rst), .pick_valid(pick_valid),
        .sel_valid(sel_valid), .sel_flush(sel_flush),
        .take(take), .tag_phase(tag_phase), .pop(pop), .close(close),
        .flush_done(flush_done), .count(count)
    );

    always_comb begin
        sel_valid = ch_valid[owner];
        sel_flush = flush_pend[owner];
        sel_data  = ch_data[owner*BYTE_W +: BYTE_W];
        out_valid = tag_phase | pop;
        out_data  = tag_phase ? tag_byte(BYTE_W'(owner)) : (pop ? sel_data : '0);
        ch_ready  = '0;
        if (pop) ch_ready[owner] = 1'b1;
        pkt_commit = close;
        pkt_len    = close ? (LEN_W'(count) + LEN_W'(1)) : '0;
    end
endmodule

// File: rtl/pmx_checker.sv
module pmx_checker #(
    parameter int N_CH        = 4,
    parameter int MAX_PAYLOAD = 511,
    localparam int LEN_W = $clog2(MAX_PAYLOAD + 2)
) (
    input logic             clk,
    input logic             rst,
    input logic [N_CH-1:0]  ch_valid,
    input logic [N_CH-1:0]  ch_ready,
    input logic             out_valid,
    input logic             pkt_commit,
    input logic [LEN_W-1:0] pkt_len
);
    logic [LEN_W:0] seen_q;

    always_ff @(posedge clk) begin
        if (rst)             seen_q <= '0;
        else if (pkt_commit) seen_q <= '0;
        else if (out_valid)  seen_q <= seen_q + 1'b1;
    end

    assert_single_pop_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ch_ready));

    assert_bytes_bounded_R3: assert property (@(posedge clk) disable iff (rst)
        seen_q <= (LEN_W+1)'(MAX_PAYLOAD + 1));

    assert_len_matches_R4: assert property (@(posedge clk) disable iff (rst)
        pkt_commit |-> (pkt_len == seen_q[LEN_W-1:0]) && (seen_q != '0));

    assert_commit_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        pkt_commit |=> !pkt_commit);

    assert_quiet_close_R4: assert property (@(posedge clk) disable iff (rst)
        pkt_commit |-> !out_valid);

    assert_no_pop_close_R7: assert property (@(posedge clk) disable iff (rst)
        pkt_commit |-> (ch_ready == '0));

    assert_pop_needs_data_R7: assert property (@(posedge clk) disable iff (rst)
        (ch_ready & ~ch_valid) == '0);
endmodule

bind pkt_mux pmx_checker #(.N_CH(N_CH), .MAX_PAYLOAD(MAX_PAYLOAD)) u_chk (
    .clk(clk), .rst(rst), .ch_valid(ch_valid), .ch_ready(ch_ready),
    .out_valid(out_valid), .pkt_commit(pkt_commit), .pkt_len(pkt_len)
);

// File: tb/pkt_mux_test.sv
module pkt_mux_test;
    localparam int N    = 4;
    localparam int MAXP = 511;
    localparam int LW   = 10;
    localparam int QD   = 2048;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [N-1:0]    ch_valid;
    logic [8*N-1:0]  ch_data;
    logic [N-1:0]    ch_flush = '0;
    logic [N-1:0]    ch_ready;
    logic            out_valid;
    logic [7:0]      out_data;
    logic            pkt_commit;
    logic [LW-1:0]   pkt_len;

    always #2 clk = ~clk;

    pkt_mux #(.N_CH(N), .MAX_PAYLOAD(MAXP)) uut (
        .clk(clk), .rst(rst), .ch_valid(ch_valid), .ch_data(ch_data),
        .ch_flush(ch_flush), .ch_ready(ch_ready), .out_valid(out_valid),
        .out_data(out_data), .pkt_commit(pkt_commit), .pkt_len(pkt_len)
    );

    // Producer FIFO models
    logic [7:0] q [N][QD];
    int head [N];
    int tail [N];
    int exp_rd [N];

    initial for (int i = 0; i < N; i++) begin head[i] = 0; tail[i] = 0; exp_rd[i] = 0; end

    always_comb
        for (int i = 0; i < N; i++) begin
            ch_valid[i]       = (head[i] != tail[i]);
            ch_data[i*8 +: 8] = q[i][head[i] % QD];
        end

    always @(posedge clk)
        for (int i = 0; i < N; i++)
            if (ch_ready[i]) head[i] <= head[i] + 1;

    // Output monitor
    logic [7:0] cap [4096];
    int cap_n = 0, cur_beg = 0, pk_n = 0;
    int pk_beg [64];
    int pk_len [64];
    int pk_seen [64];

    always @(negedge clk) if (!rst) begin
        if (out_valid) begin cap[cap_n] = out_data; cap_n++; end
        if (pkt_commit && pk_n < 64) begin
            pk_beg[pk_n]  = cur_beg;
            pk_len[pk_n]  = int'(pkt_len);
            pk_seen[pk_n] = cap_n - cur_beg;
            pk_n++;
            cur_beg = cap_n;
        end
    end

    int n_chk = 0, n_fail = 0, cyc = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic push(input int c, input int n);
        for (int k = 0; k < n; k++) begin
            q[c][tail[c]] = 8'((c << 6) ^ (tail[c] * 7) ^ (tail[c] >> 3));
            tail[c] = tail[c] + 1;
        end
    endtask

    task automatic pulse_flush(input logic [N-1:0] m);
        ch_flush = m;
        @(negedge clk);
        ch_flush = '0;
    endtask

    task automatic wait_pkts(input int target);
        for (int t = 0; t < 3000 && pk_n < target; t++) @(negedge clk);
    endtask

    task automatic check_pkt(input int idx, input int c, input int np, input string req);
        int bad;
        chk(pk_n > idx, req, pk_n, idx + 1);
        if (pk_n > idx) begin
            chk(cap[pk_beg[idx]] == 8'(c), {req, " R1 tag"}, int'(cap[pk_beg[idx]]), c);
            chk(pk_len[idx] == np + 1, {req, " R4 len"}, pk_len[idx], np + 1);
            chk(pk_seen[idx] == np + 1, {req, " R4 bytes"}, pk_seen[idx], np + 1);
            bad = 0;
            for (int k = 0; k < np; k++)
                if (cap[pk_beg[idx] + 1 + k] != q[c][exp_rd[c] + k]) bad++;
            chk(bad == 0, {req, " R2 payload"}, bad, 0);
        end
        exp_rd[c] = exp_rd[c] + np;
    endtask

    localparam int VEC [6][2] = '{'{0, 3}, '{1, 0}, '{2, 7}, '{3, 1}, '{0, 0}, '{2, 20}};

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            finish_run();
        end
    end

    initial begin
        int base, snap_cap;
        repeat (3) @(negedge clk);
        // R9: reset state
        chk(!out_valid && !pkt_commit && ch_ready == '0, "R9 during reset",
            int'({out_valid, pkt_commit, ch_ready}), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!out_valid && !pkt_commit && ch_ready == '0, "R9 after reset",
            int'({out_valid, pkt_commit, ch_ready}), 0);

        // R10: no request, no grant
        repeat (20) @(negedge clk);
        chk(cap_n == 0 && pk_n == 0, "R10 idle no output", cap_n + pk_n, 0);

        // Vector table: data then flush per channel (R1 R2 R4 R5 R6)
        foreach (VEC[v]) begin
            base = pk_n;
            push(VEC[v][0], VEC[v][1]);
            pulse_flush(N'(1) << VEC[v][0]);
            wait_pkts(base + 1);
            repeat (3) @(negedge clk);
            check_pkt(base, VEC[v][0], VEC[v][1], VEC[v][1] == 0 ? "R6 vec" : "R5 vec");
            chk(pk_n == base + 1, "R6 one packet per flush", pk_n, base + 1);
        end

        // R3: oversized payload splits at the limit
        base = pk_n;
        push(1, 600);
        pulse_flush(4'b0010);
        wait_pkts(base + 2);
        repeat (3) @(negedge clk);
        check_pkt(base, 1, MAXP, "R3 full");
        check_pkt(base + 1, 1, 600 - MAXP, "R3 tail");
        chk(head[1] == tail[1], "R7 all popped", head[1], tail[1]);

        // R8: rotation after last grant on channel 1 -> 3, 0, 1
        base = pk_n;
        push(0, 2); push(1, 2); push(3, 2);
        pulse_flush(4'b1011);
        wait_pkts(base + 3);
        repeat (3) @(negedge clk);
        check_pkt(base, 3, 2, "R8 first");
        check_pkt(base + 1, 0, 2, "R8 second");
        check_pkt(base + 2, 1, 2, "R8 third");

        // R5: granted packet without flush stays open
        base = pk_n;
        push(2, 4);
        repeat (50) @(negedge clk);
        chk(pk_n == base, "R5 open without flush", pk_n, base);
        snap_cap = cap_n;
        pulse_flush(4'b0100);
        wait_pkts(base + 1);
        repeat (3) @(negedge clk);
        check_pkt(base, 2, 4, "R5 late flush");
        chk(cap_n == snap_cap, "R5 no new bytes before flush", cap_n, snap_cap);

        finish_run();
    end
endmodule